// File: doc/BRIEF.md
# Sensor Power-Up Sequencer

This block brings an attached image sensor up from a cold start. On a start request it switches on three supply rails strictly one after another (core 1.8 V first, then 3.3 V, then the pixel supply). Each rail step waits for that rail's power-good input and for a minimum gap since the previous step. After the last rail it enables the sensor clock. One gap later it releases the sensor's active-low reset. It then waits a long settle period before it raises a ready level, which tells the controller that the first serial configuration upload may begin.

Every delay is a count of system clock cycles set by a parameter. The defaults are derived from the clock frequency: a 20 µs gap, which is above the 10 µs minimum, and an 11 ms settle, which is above the 10 ms minimum. An abort, or a start request while the block is active, takes the sensor down in reverse order: reset first, then the clock, then the rails from last to first, one gap apart. A restart then sequences back up on its own. If a rail's power-good does not arrive within a timeout, the block drops every output at once and holds a fault level until it is aborted.

Top module: `pwr_seq`

## Requirements
- R1: The rail enables rise only in index order 0, 1, 2; rail 0 rises on the clock edge that samples `start_i` high in idle.
- R2: Rail k+1 rises on the first edge at which `pg_i[k]` was high in the previous cycle and at least GAP_CYC cycles have passed since rail k rose.
- R3: `clk_en_o` rises on the first edge at which all power-good inputs were high and at least GAP_CYC cycles have passed since the last rail rose.
- R4: `sns_rst_no` goes high exactly GAP_CYC cycles after `clk_en_o` rises.
- R5: `ready_o` rises exactly SETTLE_CYC cycles after `sns_rst_no` rises, and it stays high until an abort or a start request.
- R6: If the pending rail's power-good is still low PG_TIMEOUT_CYC cycles after that rail rose, the block drops all outputs on that edge and holds `fault_o` high. A power-good that is seen in the cycle before the timeout edge still advances the sequence. In fault, `start_i` is ignored and `abort_i` returns the block to idle.
- R7: `abort_i` in an active state drops `ready_o` and steps down once on that edge. The steps down are: reset low, then clock off, then rails 2, 1, 0. Each later step comes GAP_CYC cycles after the one before it. The block is idle GAP_CYC cycles after the last step.
- R8: `start_i` while up or ready tears down as in R7 and, GAP_CYC cycles after rail 0 falls, raises rail 0 again and repeats the whole sequence.
- R9: After reset, all rail enables and `clk_en_o` are low, `sns_rst_no` is low, and `ready_o` and `fault_o` are low.
- R10: In idle, `abort_i` high together with `start_i` keeps every output off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request; a restart while active |
| abort_i | input | 1 | Abort request; takes outputs down, clears fault |
| pg_i | input | N_RAILS | Per-rail power-good |
| rail_en_o | output | N_RAILS | Per-rail enable, index 0 first |
| clk_en_o | output | 1 | Sensor clock enable |
| sns_rst_no | output | 1 | Sensor reset, active low |
| ready_o | output | 1 | Configuration may begin (level) |
| fault_o | output | 1 | Power-good timeout fault (level) |

## Verification
The assertions assume that a rail's power-good is high only while that rail is enabled and stays high once it has risen. They also assume that start and abort are one-cycle requests and that the timeout is longer than the gap. The bench keeps to these assumptions by deriving each power-good from its own rail enable with a per-rail delay that it programs, and by driving start and abort only as single-cycle pulses. Within that envelope the delays are placed on both sides of the gap and right at the timeout boundary.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP,
    ST_READY,
    ST_DOWN,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned GAP_CYC     = 4,
  parameter int unsigned SETTLE_CYC  = 10,
  parameter int unsigned TIMEOUT_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic gap_done_o,
  output logic settle_done_o,
  output logic timeout_o
);
  localparam int unsigned MAX_GS  = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int unsigned CNT_MAX = (MAX_GS > TIMEOUT_CYC) ? MAX_GS : TIMEOUT_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP    = CNT_W'(CNT_MAX - 1);
  localparam logic [CNT_W-1:0] GAP_LIM    = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LIM    = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // counts cycles since the last step, saturating at the longest limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign gap_done_o    = (cnt_q >= GAP_LIM);
  assign settle_done_o = (cnt_q >= SETTLE_LIM);
  assign timeout_o     = (cnt_q >= TMO_LIM);

  assert_cnt_mono_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode #(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned LVL_W   = 3
) (
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               clk_en_o,
  output logic               rst_n_o
);
  // level k means the first k steps are on: rails, then clock, then reset release
  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign rail_en_o[g] = (lvl_i > LVL_W'(g));
  end
  assign clk_en_o = (lvl_i > LVL_W'(N_RAILS));
  assign rst_n_o  = (lvl_i > LVL_W'(N_RAILS + 1));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int unsigned N_RAILS        = 3,
  parameter int unsigned CLK_HZ         = 100_000_000,
  parameter int unsigned GAP_CYC        = CLK_HZ / 50_000,
  parameter int unsigned SETTLE_CYC     = CLK_HZ / 100 + CLK_HZ / 1000,
  parameter int unsigned PG_TIMEOUT_CYC = CLK_HZ / 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [N_RAILS-1:0] pg_i,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               clk_en_o,
  output logic               sns_rst_no,
  output logic               ready_o,
  output logic               fault_o
);
  import pwr_seq_pkg::*;

  localparam int unsigned LVL_TOP_I = N_RAILS + 2;
  localparam int unsigned LVL_W     = $clog2(LVL_TOP_I + 1);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LVL_TOP_I);
  localparam logic [LVL_W-1:0] LVL_CLK = LVL_W'(N_RAILS + 1);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  seq_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             restart_q, restart_d;
  logic             gap_done, settle_done, timeout, step, pg_ok, stop_req;

  assign pg_ok    = &(pg_i | ~rail_en_o);
  assign stop_req = start_i | abort_i;

  always_comb begin
    state_d   = state_q;
    lvl_d     = lvl_q;
    restart_d = restart_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i && !abort_i) begin
          state_d = ST_UP;
          lvl_d   = LVL_ONE;
        end
      end
      ST_UP, ST_READY: begin
        if (stop_req) begin
          state_d   = ST_DOWN;
          lvl_d     = lvl_q - LVL_ONE;
          restart_d = !abort_i;
        end else if (state_q == ST_UP) begin
          if (lvl_q == LVL_TOP) begin
            if (settle_done) state_d = ST_READY;
          end else if (lvl_q == LVL_CLK) begin
            if (gap_done) lvl_d = lvl_q + LVL_ONE;
          end else if (pg_ok && gap_done) begin
            lvl_d = lvl_q + LVL_ONE;
          end else if (!pg_ok && timeout) begin
            state_d = ST_FAULT;
            lvl_d   = '0;
          end
        end
      end
      ST_DOWN: begin
        if (abort_i)      restart_d = 1'b0;
        else if (start_i) restart_d = 1'b1;
        if (gap_done) begin
          if (lvl_q == '0) begin
            state_d   = restart_d ? ST_UP : ST_IDLE;
            lvl_d     = restart_d ? LVL_ONE : '0;
            restart_d = 1'b0;
          end else begin
            lvl_d = lvl_q - LVL_ONE;
          end
        end
      end
      ST_FAULT: begin
        if (abort_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        lvl_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lvl_q     <= '0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      lvl_q     <= lvl_d;
      restart_q <= restart_d;
    end
  end

  assign step = (state_d != state_q) || (lvl_d != lvl_q);

  pwr_seq_timer #(
    .GAP_CYC    (GAP_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT_CYC(PG_TIMEOUT_CYC)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (step),
    .gap_done_o   (gap_done),
    .settle_done_o(settle_done),
    .timeout_o    (timeout)
  );

  pwr_seq_decode #(
    .N_RAILS(N_RAILS),
    .LVL_W  (LVL_W)
  ) u_decode (
    .lvl_i    (lvl_q),
    .rail_en_o(rail_en_o),
    .clk_en_o (clk_en_o),
    .rst_n_o  (sns_rst_no)
  );

  assign ready_o = (state_q == ST_READY);
  assign fault_o = (state_q == ST_FAULT);

  for (genvar g = 1; g < N_RAILS; g++) begin : g_chk
    assert_rail_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_en_o[g]) |-> $past(rail_en_o[g-1]));
    assert_rail_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rail_en_o[g]) |-> ($past(gap_done) && $past(pg_i[g-1])));
  end

  assert_clk_pg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> ($past(&pg_i) && $past(gap_done)));
  assert_rst_clk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sns_rst_no) |-> ($past(clk_en_o) && $past(gap_done)));
  assert_ready_settle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(settle_done) && sns_rst_no));
  assert_ready_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i && !abort_i) |=> ready_o);
  assert_fault_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (rail_en_o == '0 && !clk_en_o && !sns_rst_no && !ready_o));
  assert_down_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> !sns_rst_no);
  assert_idle_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && abort_i) |=> (state_q == ST_IDLE));
endmodule

// File: tb/pwr_seq_tb.sv
`timescale 1ns/1ps
module pwr_seq_tb;
  localparam int N = 3;
  localparam int G = 4;
  localparam int S = 10;
  localparam int T = 20;

  // stimulus: per-rail power-good delay; expected: fault flag and ready or fault time
  localparam int NV = 6;
  localparam int VD0[NV]   = '{0, 6, 3, 19, 0, 25};
  localparam int VD1[NV]   = '{0, 2, 4, 0, 20, 0};
  localparam int VD2[NV]   = '{0, 9, 0, 0, 0, 0};
  localparam int VFLT[NV]  = '{0, 0, 0, 0, 1, 1};
  localparam int VTIME[NV] = '{26, 35, 27, 42, 24, 20};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
  logic [N-1:0] pg, rail_en;
  logic clk_en, sns_rst_n, ready, fault;
  logic [6:0] sig;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int pg_dly[N] = '{default: 0};
  int pg_cnt[N] = '{default: 0};
  int rise[7], fall[7];

  always #2 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  // power-good model: rail k reports good pg_dly[k] cycles after its enable
  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (!rail_en[k])              pg_cnt[k] <= 0;
      else if (pg_cnt[k] < 100000)  pg_cnt[k] <= pg_cnt[k] + 1;
    end
  end
  always_comb begin
    for (int k = 0; k < N; k++) pg[k] = rail_en[k] && (pg_cnt[k] >= pg_dly[k]);
  end

  assign sig = {fault, ready, sns_rst_n, clk_en, rail_en};

  pwr_seq #(
    .N_RAILS(N), .GAP_CYC(G), .SETTLE_CYC(S), .PG_TIMEOUT_CYC(T)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort), .pg_i(pg),
    .rail_en_o(rail_en), .clk_en_o(clk_en), .sns_rst_no(sns_rst_n),
    .ready_o(ready), .fault_o(fault)
  );

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle request, then record first rise/fall time of each output over ncyc cycles
  task automatic run(bit s, bit a, int ncyc);
    logic [6:0] prev;
    int base;
    @(negedge clk);
    start = s;
    abort = a;
    base  = cyc + 1;
    prev  = sig;
    for (int k = 0; k < 7; k++) begin
      rise[k] = -1;
      fall[k] = -1;
    end
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      start = 1'b0;
      abort = 1'b0;
      for (int k = 0; k < 7; k++) begin
        if (sig[k] && !prev[k] && rise[k] < 0) rise[k] = cyc - base;
        if (!sig[k] && prev[k] && fall[k] < 0) fall[k] = cyc - base;
      end
      prev = sig;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int e1, e2, e3, e4, e5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 rails off", int'(rail_en), 0);
    chk("R9 clock off", int'(clk_en), 0);
    chk("R9 reset held", int'(sns_rst_n), 0);
    chk("R9 ready low", int'(ready), 0);
    chk("R9 fault low", int'(fault), 0);

    for (int v = 0; v < NV; v++) begin
      pg_dly[0] = VD0[v];
      pg_dly[1] = VD1[v];
      pg_dly[2] = VD2[v];
      run(1'b1, 1'b0, VTIME[v] + 3);
      if (VFLT[v] == 0) begin
        e1 = mx(G, VD0[v] + 1);
        e2 = e1 + mx(G, VD1[v] + 1);
        e3 = e2 + mx(G, VD2[v] + 1);
        e4 = e3 + G;
        e5 = e4 + S;
        chk("R1 rail0 on start edge", rise[0], 0);
        chk("R2 rail1 time", rise[1], e1);
        chk("R2 rail2 time", rise[2], e2);
        chk("R3 clock time", rise[3], e3);
        chk("R4 reset release time", rise[4], e4);
        chk("R5 ready time", rise[5], e5);
        chk("R5 ready table time", rise[5], VTIME[v]);
        chk("R6 no fault", rise[6], -1);
        run(1'b0, 1'b1, 5 * G + 2);
        chk("R7 all off after abort", int'(sig), 0);
      end else begin
        chk("R6 fault time", rise[6], VTIME[v]);
        chk("R6 outputs off in fault", int'(sig), 64);
        chk("R1 rail2 never on", rise[2], -1);
        run(1'b0, 1'b1, 2);
        chk("R6 abort clears fault", int'(fault), 0);
      end
    end

    pg_dly = '{default: 0};
    // R5 hold, R7 teardown from ready
    run(1'b1, 1'b0, 30);
    chk("R5 ready reached", int'(ready), 1);
    run(1'b0, 1'b0, 50);
    chk("R5 ready held", fall[5], -1);
    chk("R5 ready still high", int'(ready), 1);
    run(1'b0, 1'b1, 5 * G + 3);
    chk("R7 ready drop", fall[5], 0);
    chk("R7 reset first", fall[4], 0);
    chk("R7 clock off", fall[3], G);
    chk("R7 rail2 off", fall[2], 2 * G);
    chk("R7 rail1 off", fall[1], 3 * G);
    chk("R7 rail0 off", fall[0], 4 * G);
    chk("R7 no restart", rise[0], -1);

    // R8 restart while ready
    run(1'b1, 1'b0, 30);
    run(1'b1, 1'b0, 50);
    chk("R8 reset first", fall[4], 0);
    chk("R8 rail0 off", fall[0], 4 * G);
    chk("R8 rail0 back on", rise[0], 5 * G);
    chk("R8 ready again", rise[5], 5 * G + 4 * G + S);
    run(1'b0, 1'b1, 5 * G + 2);

    // R7 abort mid sequence (two rails up)
    run(1'b1, 1'b0, 6);
    run(1'b0, 1'b1, 10);
    chk("R7 mid rail1 off", fall[1], 0);
    chk("R7 mid rail0 off", fall[0], G);
    chk("R7 mid rail2 never", rise[2], -1);
    chk("R7 mid all off", int'(sig), 0);

    // R10 abort beats start in idle
    run(1'b1, 1'b1, 10);
    chk("R10 no rail", rise[0], -1);
    chk("R10 all off", int'(sig), 0);

    // R6 start ignored while faulted
    pg_dly[0] = 1000;
    run(1'b1, 1'b0, T + 2);
    chk("R6 fault set", int'(fault), 1);
    run(1'b1, 1'b0, 10);
    chk("R6 start ignored rail", rise[0], -1);
    chk("R6 start ignored fault", int'(fault), 1);
    run(1'b0, 1'b1, 2);
    chk("R6 abort to idle", int'(sig), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule